// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the execute stage arithmetic unit of a 32-bit load-store core. Each cycle in which `op_valid` is high it takes an opcode and two operands, computes a move, inverted move, add, subtract, compare, AND or OR, and on the next clock edge presents the registered result together with a one-cycle write-enable for the destination register. The same edge updates a four-flag condition field (negative, zero, carry, overflow) that sits in the upper nibble of a 32-bit program status word. The lower 28 bits of that word stay at zero.

Compare is a subtract whose only effect is on the flags. No destination write is issued and the result output keeps its old value. Logical and move operations refresh only the negative and zero flags, so a carry or overflow from an earlier arithmetic operation is still there for a later conditional test. A combinational condition evaluator reads the registered flags and reports whether the condition chosen by `cond_sel` holds. Branch logic uses this output.

Top module: `flag_alu`

## Requirements
- R1: Status bit 31 (negative) equals bit 31 of the computed value after every flag-updating operation. For compare, the computed value is A minus B.
- R2: Status bit 30 (zero) is set exactly when all 32 bits of the computed value are zero.
- R3: For add (op_code 2), status bit 29 (carry) is the carry out of the 32-bit unsigned sum.
- R4: For subtract (op_code 3) and compare (op_code 4), status bit 29 is set when no borrow occurs, that is when A ≥ B as unsigned numbers.
- R5: For add, subtract and compare, status bit 28 (overflow) is set when the signed two's-complement result does not fit in 32 bits.
- R6: Move (op_code 0) yields B. Move-not (op_code 1) yields the bitwise complement of B.
- R7: Add yields A+B, subtract yields A−B, AND (op_code 5) yields A&B and OR (op_code 6) yields A|B, each modulo 2^32.
- R8: Compare updates all four flags but never raises `dest_we` and leaves `result` unchanged.
- R9: Move, move-not, AND and OR update the negative and zero flags and keep the carry and overflow flags at their prior values.
- R10: `cond_hold` follows the registered flags by `cond_sel`: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always true, 15 always false.
- R11: Results and flags change on the first clock edge after `op_valid` is sampled high. `dest_we` is high for exactly that one cycle. With `op_valid` low, or with the reserved op_code 7, nothing changes and `dest_we` stays low.
- R12: Synchronous active-low reset clears `result`, `dest_we` and the whole status word. Status bits 27:0 read zero at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select (0 mov, 1 mvn, 2 add, 3 sub, 4 cmp, 5 and, 6 or, 7 reserved) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| cond_sel | input | 4 | Condition to evaluate against the flags |
| result | output | 32 | Registered operation result |
| dest_we | output | 1 | One-cycle destination write strobe |
| psr | output | 32 | Status word, flags in bits 31:28 |
| cond_hold | output | 1 | Selected condition is true |

## Verification
`result`, `dest_we` and `psr` are each one register stage behind the strobe, so they are due on the clock edge right after `op_valid` is sampled. `cond_hold` is combinational from the registered flags and `cond_sel`, so it becomes valid in that same cycle once `cond_sel` settles. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the following falling edge, when both the registered outputs and the condition output are stable. It then drops `op_valid` and checks one cycle later that the write strobe has fallen and that no state has moved.

// File: rtl/flag_alu_pkg.sv
// Package: shared opcode, flag and condition types for the flag-setting ALU.
// Assumes a 3-bit opcode and a 4-bit condition selector.
package flag_alu_pkg;

    typedef enum logic [2:0] {
        OP_MOV = 3'd0,
        OP_MVN = 3'd1,
        OP_ADD = 3'd2,
        OP_SUB = 3'd3,
        OP_CMP = 3'd4,
        OP_AND = 3'd5,
        OP_ORR = 3'd6,
        OP_RSV = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic [3:0] {
        CC_ZSET  = 4'd0,
        CC_ZCLR  = 4'd1,
        CC_CSET  = 4'd2,
        CC_CCLR  = 4'd3,
        CC_NSET  = 4'd4,
        CC_NCLR  = 4'd5,
        CC_VSET  = 4'd6,
        CC_VCLR  = 4'd7,
        CC_UGT   = 4'd8,
        CC_ULE   = 4'd9,
        CC_SGE   = 4'd10,
        CC_SLT   = 4'd11,
        CC_SGT   = 4'd12,
        CC_SLE   = 4'd13,
        CC_TRUE  = 4'd14,
        CC_FALSE = 4'd15
    } cond_e;

    localparam int FLAG_COUNT = 4;

endpackage

// File: rtl/flag_alu_datapath.sv
// Module: combinational operation unit. Computes the result of the selected
// opcode and the next flag values. Assumes flags_cur holds the registered
// flags so that logical operations can pass C and V through unchanged.
module flag_alu_datapath
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  nzcv_t         flags_cur,
    output logic [W-1:0]  value,
    output nzcv_t         flags_nxt,
    output logic          writes_dest,
    output logic          touches_flags
);

    localparam int MSB = W - 1;

    logic          is_arith;
    logic          is_sub;
    logic [W-1:0]  b_eff;
    logic [W:0]    sum_ext;
    logic [W-1:0]  sum;
    logic          carry_out;
    logic          ovf;

    // Classify the opcode into arithmetic and subtracting groups.
    always_comb begin
        is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
        is_sub   = (op == OP_SUB) || (op == OP_CMP);
    end

    // Shared adder: subtraction is done as A + ~B + 1.
    always_comb begin
        b_eff     = is_sub ? ~b : b;
        sum_ext   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
        sum       = sum_ext[W-1:0];
        carry_out = sum_ext[W];
        ovf       = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end

    // Select the result value for the operation.
    always_comb begin
        unique case (op)
            OP_MOV:  value = b;
            OP_MVN:  value = ~b;
            OP_ADD,
            OP_SUB,
            OP_CMP:  value = sum;
            OP_AND:  value = a & b;
            OP_ORR:  value = a | b;
            default: value = '0;
        endcase
    end

    // Decide which side effects this opcode has.
    always_comb begin
        writes_dest   = (op != OP_CMP) && (op != OP_RSV);
        touches_flags = (op != OP_RSV);
    end

    // Form the next flags; logical ops keep carry and overflow.
    always_comb begin
        flags_nxt.n = value[MSB];
        flags_nxt.z = (value == '0);
        flags_nxt.c = is_arith ? carry_out : flags_cur.c;
        flags_nxt.v = is_arith ? ovf       : flags_cur.v;
    end

endmodule

// File: rtl/flag_alu_state.sv
// Module: result, write strobe and flag registers. Loads on the edge after
// a strobe. Assumes the enables come from the datapath classification and
// that the strobe is the raw op_valid input.
module flag_alu_state
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          res_en,
    input  logic          flag_en,
    input  logic [W-1:0]  res_nxt,
    input  nzcv_t         flags_nxt,
    output logic [W-1:0]  result_q,
    output logic          dest_we_q,
    output nzcv_t         flags_q
);

    // Result register, loaded only by operations that write a destination.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_q <= '0;
        else if (strobe && res_en)
            result_q <= res_nxt;
    end

    // Write strobe, high for one cycle per writing operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dest_we_q <= 1'b0;
        else
            dest_we_q <= strobe && res_en;
    end

    // Flag register, loaded by every non-reserved operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (strobe && flag_en)
            flags_q <= flags_nxt;
    end

    AST_IDLE_FLAGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(flags_q) && $stable(result_q)); // R11
    AST_WE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> !dest_we_q); // R11
    AST_Z_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        dest_we_q |-> (flags_q.z == (result_q == '0))); // R2
    AST_N_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        dest_we_q |-> (flags_q.n == result_q[W-1])); // R1

endmodule

// File: rtl/flag_alu_cond.sv
// Module: condition evaluator. Maps a 4-bit selector onto the registered
// flags. Assumes the flags are stable for the whole cycle.
module flag_alu_cond
    import flag_alu_pkg::*;
(
    input  nzcv_t       flags,
    input  logic [3:0]  sel,
    output logic        hold
);

    logic sge;

    // Signed greater-or-equal term shared by several conditions.
    always_comb sge = (flags.n == flags.v);

    // Decode the selector into one condition.
    always_comb begin
        unique case (cond_e'(sel))
            CC_ZSET:  hold = flags.z;
            CC_ZCLR:  hold = !flags.z;
            CC_CSET:  hold = flags.c;
            CC_CCLR:  hold = !flags.c;
            CC_NSET:  hold = flags.n;
            CC_NCLR:  hold = !flags.n;
            CC_VSET:  hold = flags.v;
            CC_VCLR:  hold = !flags.v;
            CC_UGT:   hold = flags.c && !flags.z;
            CC_ULE:   hold = !flags.c || flags.z;
            CC_SGE:   hold = sge;
            CC_SLT:   hold = !sge;
            CC_SGT:   hold = !flags.z && sge;
            CC_SLE:   hold = flags.z || !sge;
            CC_TRUE:  hold = 1'b1;
            default:  hold = 1'b0;
        endcase
    end

endmodule

// File: rtl/flag_alu.sv
// Module: top of the flag-setting ALU. Ties the datapath, the state
// registers and the condition evaluator together and forms the status word.
// Assumes the register file and branch logic sit outside this block.
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic [3:0]    cond_sel,
    output logic [W-1:0]  result,
    output logic          dest_we,
    output logic [W-1:0]  psr,
    output logic          cond_hold
);

    localparam int SPARE_BITS = W - FLAG_COUNT;

    alu_op_e       op;
    logic [W-1:0]  value;
    nzcv_t         flags_nxt;
    nzcv_t         flags_q;
    logic          writes_dest;
    logic          touches_flags;

    // Give the raw opcode its enumerated type.
    always_comb op = alu_op_e'(op_code);

    flag_alu_datapath #(.W(W)) u_dp (
        .op            (op),
        .a             (opnd_a),
        .b             (opnd_b),
        .flags_cur     (flags_q),
        .value         (value),
        .flags_nxt     (flags_nxt),
        .writes_dest   (writes_dest),
        .touches_flags (touches_flags)
    );

    flag_alu_state #(.W(W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (op_valid),
        .res_en    (writes_dest),
        .flag_en   (touches_flags),
        .res_nxt   (value),
        .flags_nxt (flags_nxt),
        .result_q  (result),
        .dest_we_q (dest_we),
        .flags_q   (flags_q)
    );

    flag_alu_cond u_cond (
        .flags (flags_q),
        .sel   (cond_sel),
        .hold  (cond_hold)
    );

    // Build the status word: flags on top, spare bits zero.
    always_comb psr = {flags_q, {SPARE_BITS{1'b0}}};

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd4) |=> (!dest_we && $stable(result))); // R8
    AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 3'd0 || op_code == 3'd1 || op_code == 3'd5 || op_code == 3'd6))
        |=> (psr[29:28] == $past(psr[29:28]))); // R9
    AST_SUB_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 3'd3 || op_code == 3'd4))
        |=> (psr[29] == ($past(opnd_a) >= $past(opnd_b)))); // R4
    AST_RSV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd7) |=> (!dest_we && $stable(psr))); // R11

endmodule

// File: tb/tb_flag_alu.sv
module tb_flag_alu;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [3:0]  cond_sel;
    logic [31:0] result;
    logic        dest_we;
    logic [31:0] psr;
    logic        cond_hold;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    flag_alu dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .cond_sel(cond_sel),
        .result(result), .dest_we(dest_we), .psr(psr), .cond_hold(cond_hold)
    );

    // {op, a, b, expected result, expected we, expected NZCV}
    localparam int NV = 16;
    localparam logic [103:0] VEC [NV] = '{
        {3'd2, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1, 4'b1001},
        {3'd2, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 4'b0110},
        {3'd5, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'h00000000, 1'b1, 4'b0110},
        {3'd6, 32'h80000000, 32'h00000001, 32'h80000001, 1'b1, 4'b1010},
        {3'd3, 32'h00000005, 32'h00000003, 32'h00000002, 1'b1, 4'b0010},
        {3'd3, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 1'b1, 4'b1000},
        {3'd0, 32'hDEADBEEF, 32'h00000000, 32'h00000000, 1'b1, 4'b0100},
        {3'd3, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 4'b0011},
        {3'd1, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 1'b1, 4'b1011},
        {3'd4, 32'h00000007, 32'h00000007, 32'hFFFFFFFF, 1'b0, 4'b0110},
        {3'd2, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 4'b0111},
        {3'd4, 32'h00000001, 32'h00000002, 32'h00000000, 1'b0, 4'b1000},
        {3'd0, 32'h00000000, 32'h12345678, 32'h12345678, 1'b1, 4'b0000},
        {3'd6, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 4'b0100},
        {3'd2, 32'h12345678, 32'h11111111, 32'h23456789, 1'b1, 4'b0000},
        {3'd1, 32'h00000000, 32'h0000FFFF, 32'hFFFF0000, 1'b1, 4'b1000}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit cond_model(input logic [3:0] f, input logic [3:0] s);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (s)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c && !z;
            4'd9:  return !c || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Strobe one operation, then sample one cycle later with the strobe low.
    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b;
        @(negedge clk);
        op_valid = 1'b0;
        #0.5;
    endtask

    task automatic sweep_cond(input logic [3:0] f);
        for (int s = 0; s < 16; s++) begin
            cond_sel = s[3:0];
            #0.1;
            check(cond_hold == cond_model(f, s[3:0]), "R10 cond_hold",
                  {31'd0, cond_hold}, {31'd0, cond_model(f, s[3:0])});
        end
    endtask

    initial begin
        logic [31:0] keep_res;
        logic [31:0] keep_psr;
        rst_n = 1'b0; op_valid = 1'b0; op_code = 3'd0;
        opnd_a = '0; opnd_b = '0; cond_sel = 4'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R12: reset state
        check(psr == 32'h0, "R12 psr reset", psr, 32'h0);
        check(result == 32'h0, "R12 result reset", result, 32'h0);
        check(dest_we == 1'b0, "R12 dest_we reset", {31'd0, dest_we}, 32'h0);

        // Vector table: R1..R9, R11 timing, R10 per flag state
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  vop;
            logic [31:0] va, vb, vr;
            logic        vw;
            logic [3:0]  vf;
            {vop, va, vb, vr, vw, vf} = VEC[i];
            issue(vop, va, vb);
            check(result == vr, "R6/R7/R8 result", result, vr);
            check(dest_we == vw, "R8/R11 dest_we", {31'd0, dest_we}, {31'd0, vw});
            check(psr[31:28] == vf, "R1-flags R2 R3 R4 R5 R9 nzcv", {28'd0, psr[31:28]}, {28'd0, vf});
            check(psr[27:0] == 28'd0, "R12 spare bits", psr, {vf, 28'd0});
            sweep_cond(vf);
            @(negedge clk); #0.5;
            check(dest_we == 1'b0, "R11 dest_we one cycle", {31'd0, dest_we}, 32'h0);
        end

        // R11: idle cycles change nothing
        keep_res = result; keep_psr = psr;
        opnd_a = 32'hFFFFFFFF; opnd_b = 32'h1; op_code = 3'd2;
        repeat (3) @(negedge clk);
        #0.5;
        check(result == keep_res && psr == keep_psr, "R11 idle no change", psr, keep_psr);
        check(dest_we == 1'b0, "R11 idle no write", {31'd0, dest_we}, 32'h0);

        // R11: reserved opcode 7 does nothing
        issue(3'd7, 32'h0, 32'h0);
        check(dest_we == 1'b0, "R11 reserved no write", {31'd0, dest_we}, 32'h0);
        check(psr == keep_psr, "R11 reserved keeps flags", psr, keep_psr);
        check(result == keep_res, "R11 reserved keeps result", result, keep_res);

        // R8: compare result register untouched with distinct value
        issue(3'd4, 32'h00000000, 32'h00000001);
        check(result == keep_res, "R8 cmp keeps result", result, keep_res);
        check(psr == 32'h80000000, "R4 cmp 0-1 borrow", psr, 32'h80000000);

        // R5: subtract positive minus negative overflows
        issue(3'd3, 32'h7FFFFFFF, 32'hFFFFFFFF);
        check(result == 32'h80000000, "R7 sub wrap", result, 32'h80000000);
        check(psr == 32'h90000000, "R5 sub overflow", psr, 32'h90000000);

        // R12: reset mid-run clears everything
        issue(3'd1, 32'h0, 32'h0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        check(psr == 32'h0 && result == 32'h0, "R12 reset mid-run", psr, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule